// File: doc/BRIEF.md
# Boot-Time Protection Level Loader

This block runs once after every reset, before the rest of the chip may execute code. It fetches five 64-bit option sections, one after another, from a nonvolatile-memory read port and keeps them in hidden shadow registers. Each section carries a 32-bit option value together with its bitwise inverse. After all five have arrived, the block checks every value against its inverse and publishes five 32-bit option words that software can read.

A section that fails the check is replaced by all ones, and a per-section error bit records the failure. The low byte of option word 0 is the protection byte. It is decoded into one of three readout-protection levels. Two exact codes pick the open and locked levels, and every other value falls to the middle level. The level drives the enables for debug, SRAM access and flash readout.

All three enables stay closed until the load has finished. Because of this there is never a window in which access opens early.

Top module: `boot_optload`

## Requirements
- R1: After reset is released, the block requests sections at `rd_addr` 0, 1, 2, 3 and 4 in that order. It makes exactly one accepted request per section and waits for `rd_valid` before it requests the next section.
- R2: A request is accepted on a clock edge where `rd_req` and `rd_ready` are both high. `rd_req` then drops in the next cycle. While `rd_ready` is low, `rd_req` and `rd_addr` hold.
- R3: In each section, bits [31:0] hold the value and bits [63:32] hold its complement. When the high half equals the bitwise inverse of the low half, the published word for that section is the low half.
- R4: On a mismatch in section i, word i of `opt_words` (bits [32*i+31:32*i]) becomes 32'hFFFF_FFFF and `sec_err[i]` is set. Sections that match are unaffected.
- R5: The protection byte is bits [7:0] of word 0. The value 8'hAA gives `prot_level` 0 and 8'hCC gives 2. Any other value, including the 8'hFF default and single-bit variants of 8'hCC, gives 1.
- R6: At level 0, all three enables are high. At level 1, `dbg_en` and `sram_en` are high and `flash_en` is low. At level 2, all three are low.
- R7: While `done` is low, `dbg_en`, `sram_en` and `flash_en` are low and `prot_level` reads 2.
- R8: `done` rises once the load is complete and then stays high. The published words and error bits then stay stable until the next reset.
- R9: During reset, `done`, `rd_req`, `sec_err` and `opt_words` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts a load |
| rd_req | output | 1 | Read request to the option memory |
| rd_addr | output | 3 | Section index being requested |
| rd_ready | input | 1 | Memory accepts the request this cycle |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 64 | Section contents: complement high, value low |
| done | output | 1 | Load finished, outputs valid |
| opt_words | output | 160 | Five published 32-bit option words, word i at bits [32*i+31:32*i] |
| sec_err | output | 5 | Per-section complement-mismatch flag |
| prot_level | output | 2 | Decoded protection level 0, 1 or 2 |
| dbg_en | output | 1 | Debug access enable |
| sram_en | output | 1 | SRAM access enable |
| flash_en | output | 1 | Flash readout enable |

## Verification
Some rules can be checked on every cycle, and the assertions cover them. These are the request handshake, the closed enables before `done`, a sticky `done` with frozen outputs, all-ones words for flagged sections and an open level for the 8'hAA code. Other behaviour only shows in the bench scenarios. These include the address order, the level decode across the 8'hAA, 8'hCC, 8'hFF, flipped-bit and arbitrary protection bytes, and a mismatch placed in each section in turn. They also cover a stalled memory and the state in reset.

// File: rtl/boot_optload.sv
module boot_optload #(
  parameter int NSEC = 5,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    rd_req,
  output logic [$clog2(NSEC)-1:0] rd_addr,
  input  logic                    rd_ready,
  input  logic                    rd_valid,
  input  logic [2*W-1:0]          rd_data,
  output logic                    done,
  output logic [NSEC*W-1:0]       opt_words,
  output logic [NSEC-1:0]         sec_err,
  output logic [1:0]              prot_level,
  output logic                    dbg_en,
  output logic                    sram_en,
  output logic                    flash_en
);
  localparam int AW = $clog2(NSEC);
  localparam logic [AW-1:0] LAST = AW'(NSEC - 1);
  localparam logic [7:0] CODE_OPEN = 8'hAA;
  localparam logic [7:0] CODE_LOCK = 8'hCC;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_CHECK, S_COPY, S_DONE} st_t;

  st_t            state;
  logic [AW-1:0]  idx;
  logic [2*W-1:0] shadow [NSEC];
  logic [1:0]     lvl_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      sec_err   <= '0;
      opt_words <= '0;
      for (int i = 0; i < NSEC; i++) shadow[i] <= '0;
    end else begin
      case (state)
        S_IDLE: state <= S_REQ;
        S_REQ:  if (rd_ready) state <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          shadow[idx] <= rd_data;
          if (idx == LAST) state <= S_CHECK;
          else begin
            idx   <= idx + 1'b1;
            state <= S_REQ;
          end
        end
        S_CHECK: begin
          for (int i = 0; i < NSEC; i++)
            sec_err[i] <= shadow[i][2*W-1:W] != ~shadow[i][W-1:0];
          state <= S_COPY;
        end
        S_COPY: begin
          for (int i = 0; i < NSEC; i++)
            opt_words[i*W +: W] <= sec_err[i] ? {W{1'b1}} : shadow[i][W-1:0];
          state <= S_DONE;
        end
        S_DONE:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_req  = state == S_REQ;
  assign rd_addr = idx;
  assign done    = state == S_DONE;

  assign lvl_raw    = (opt_words[7:0] == CODE_OPEN) ? 2'd0 :
                      (opt_words[7:0] == CODE_LOCK) ? 2'd2 : 2'd1;
  assign prot_level = done ? lvl_raw : 2'd2;
  assign dbg_en     = prot_level != 2'd2;
  assign sram_en    = prot_level != 2'd2;
  assign flash_en   = prot_level == 2'd0;

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n) rd_req && rd_ready |=> !rd_req); // R2
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) rd_req && !rd_ready |=> rd_req && $stable(rd_addr)); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> rd_addr <= LAST); // R1
  AST_LOCKED_EARLY: assert property (@(posedge clk) disable iff (!rst_n) !done |-> !dbg_en && !sram_en && !flash_en && prot_level == 2'd2); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R8
  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) done && $past(done) |-> $stable(opt_words) && $stable(sec_err)); // R8
  AST_OPEN_CODE: assert property (@(posedge clk) disable iff (!rst_n) done && opt_words[7:0] == CODE_OPEN |-> dbg_en && sram_en && flash_en); // R5

  for (genvar g = 0; g < NSEC; g++) begin : g_err_chk
    AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n) done && sec_err[g] |-> opt_words[g*W +: W] == {W{1'b1}}); // R4
  end
endmodule

// File: tb/boot_optload_test.sv
module boot_optload_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSEC = 5;
  localparam int W = 32;

  logic clk, rst_n, rd_req, rd_ready, rd_valid, done;
  logic [2:0] rd_addr;
  logic [63:0] rd_data;
  logic [NSEC*W-1:0] opt_words;
  logic [NSEC-1:0] sec_err;
  logic [1:0] prot_level;
  logic dbg_en, sram_en, flash_en;

  boot_optload uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .opt_words(opt_words), .sec_err(sec_err),
    .prot_level(prot_level), .dbg_en(dbg_en), .sram_en(sram_en), .flash_en(flash_en)
  );

  logic [63:0] mem [NSEC];
  int checks = 0, fails = 0, cyc = 0;
  int stall_mode = 0, nreq = 0, pend = 0, cnt = 0, paddr = 0;
  int req_log [8];
  bit lock_viol = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    rd_valid = 1'b0;
    if (pend != 0) begin
      if (cnt == 0) begin
        rd_valid = 1'b1;
        rd_data  = mem[paddr];
        pend     = 0;
      end else cnt--;
    end
    rd_ready = (stall_mode == 0) || (cyc % 3 == 0);
    if (rst_n && rd_req && rd_ready && pend == 0 && !rd_valid) begin
      pend  = 1;
      cnt   = 1;
      paddr = int'(rd_addr);
      if (nreq < 8) req_log[nreq] = int'(rd_addr);
      nreq++;
    end
    if (rst_n && !done && (dbg_en || sram_en || flash_en)) lock_viol = 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_level(input logic [7:0] pb);
    if (pb == 8'hAA) return 2'd0;
    if (pb == 8'hCC) return 2'd2;
    return 2'd1;
  endfunction

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !rd_req, "R9", "done/req in reset", {62'd0, done, rd_req}, 64'd0);
    check(sec_err == '0, "R9", "sec_err in reset", 64'(sec_err), 64'd0);
    check(opt_words == '0, "R9", "opt_words in reset", opt_words[63:0], 64'd0);
    check(!dbg_en && !sram_en && !flash_en && prot_level == 2'd2, "R7", "enables in reset",
          {59'd0, prot_level, dbg_en, sram_en, flash_en}, {59'd0, 2'd2, 3'b000});
  endtask

  task automatic run_boot(input logic [7:0] pb, input logic [4:0] emask, input int stall, input string tag);
    logic [31:0] exp_w [NSEC];
    logic [NSEC*W-1:0] snap;
    logic [1:0] el;
    int t;
    for (int i = 0; i < NSEC; i++) begin
      logic [31:0] v, h;
      v = 32'h1357_9B00 ^ (32'(i) * 32'h0101_0110);
      if (i == 0) v[7:0] = pb;
      h = ~v;
      if (emask[i]) h = h ^ 32'h0040_0000;
      mem[i] = {h, v};
      exp_w[i] = emask[i] ? 32'hFFFF_FFFF : v;
    end
    stall_mode = stall; nreq = 0; pend = 0; lock_viol = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    check(done, "R8", {tag, " done after load"}, 64'(done), 64'd1);
    check(nreq == NSEC, "R1", {tag, " request count"}, 64'(nreq), 64'(NSEC));
    for (int i = 0; i < NSEC && i < nreq; i++)
      check(req_log[i] == i, "R1", {tag, " request order"}, 64'(req_log[i]), 64'(i));
    for (int i = 0; i < NSEC; i++)
      check(opt_words[i*W +: W] == exp_w[i], emask[i] ? "R4" : "R3", {tag, " word"},
            64'(opt_words[i*W +: W]), 64'(exp_w[i]));
    check(sec_err == emask, "R4", {tag, " sec_err"}, 64'(sec_err), 64'(emask));
    el = exp_level(exp_w[0][7:0]);
    check(prot_level == el, "R5", {tag, " level"}, 64'(prot_level), 64'(el));
    check({dbg_en, sram_en, flash_en} == {el != 2'd2, el != 2'd2, el == 2'd0}, "R6", {tag, " enables"},
          64'({dbg_en, sram_en, flash_en}), 64'({el != 2'd2, el != 2'd2, el == 2'd0}));
    check(!lock_viol, "R7", {tag, " enables closed before done"}, 64'(lock_viol), 64'd0);
    snap = opt_words;
    repeat (8) @(negedge clk);
    check(done && opt_words == snap && nreq == NSEC, "R8", {tag, " outputs hold after done"},
          {63'd0, done}, 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; rd_ready = 1'b0; rd_valid = 1'b0; rd_data = '0;
    reset_check();
    run_boot(8'hAA, 5'b00000, 0, "open");
    run_boot(8'hCC, 5'b00000, 0, "locked");
    run_boot(8'hFF, 5'b00000, 0, "default");
    run_boot(8'hCD, 5'b00000, 0, "flipped");
    run_boot(8'h37, 5'b00000, 0, "arbitrary");
    for (int s = 0; s < NSEC; s++) run_boot(8'hCC, 5'(1 << s), 0, "mismatch");
    run_boot(8'hAA, 5'b11111, 0, "all_bad");
    run_boot(8'hAA, 5'b00000, 1, "stalled_R2");
    run_boot(8'hCC, 5'b00100, 1, "stalled_err");
    reset_check();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule